// File: doc/BRIEF.md
# ASCII Volume Command Parser

This block takes a stream of bytes, one byte per cycle when a valid flag is high. The bytes may come from a serial receiver or from user-data bits carried alongside audio. It recognises short printable volume commands and keeps a left and a right volume register. A command starts with the character 'V' and ends with a carriage return (0x0D). Between them come two volume fields written as hexadecimal characters. In the long form each field has a marker in front of it: 'L' before the left value and 'R' before the right value, as in "VL42R9A" followed by CR. The short form leaves out both markers, as in "V429A" followed by CR.

Every speaker in a system runs the same logic. A static channel-select pin chooses which of the two stored volumes drives the single gain output, so each unit applies its own value and ignores the other. Both volumes are written together, and only when a complete command ends at the right place. Any 'V' starts a new command, so the parser recovers after corrupted bytes.

Top module: `vol_cmd_parser`

## Requirements
- R1: After a synchronous active-low reset, left_vol and right_vol read 0x00, and update and error read 0.
- R2: A long-form command ('V', 'L', two hex digits, 'R', two hex digits, CR) writes both volumes. The new values and a one-cycle update pulse appear in the cycle after the clock edge that accepts the CR byte. The first digit of each field is the high nibble.
- R3: A short-form command ('V', two left digits, two right digits, CR, six bytes in total) writes both volumes with the same timing as R2.
- R4: Hex digits '0'-'9', 'A'-'F' and 'a'-'f' are all accepted, and a lowercase letter decodes to the same value as its uppercase form.
- R5: Any byte other than a hex digit or 'V' in a digit position abandons the command. A CR that arrives early counts as such a byte. error then pulses for one cycle after that byte, update stays 0 and both volumes are left unchanged.
- R6: In the long form, a byte other than 'R' (or 'V') at the right-marker position abandons the command with an error pulse. After the last right digit, a byte other than CR (or 'V') abandons the command with an error pulse. At the opcode position, a byte that is neither 'L', a hex digit nor 'V' does the same.
- R7: A 'V' in any position restarts parsing without raising error. Bytes received while no command is open are ignored without error. This includes the bytes that follow an abandoned command.
- R8: The gain output equals left_vol when chan_sel is 0 and right_vol when chan_sel is 1, with no register in between.
- R9: The volumes change only together with an update pulse. Cycles with byte_valid low have no effect, whatever byte_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | byte_data holds a byte this cycle |
| byte_data | input | 8 | Incoming byte |
| chan_sel | input | 1 | 0 applies the left volume, 1 applies the right volume |
| left_vol | output | 8 | Stored left volume |
| right_vol | output | 8 | Stored right volume |
| gain | output | 8 | Volume applied by this speaker |
| update | output | 1 | One-cycle pulse when new volumes are stored |
| error | output | 1 | One-cycle pulse when a command is abandoned |

## Verification
A parser stuck in the wrong state shows up within one command. A valid terminating CR then gives no update pulse, or a stray byte gives an error pulse. A wrong digit count or nibble order shows up as wrong values on left_vol and right_vol at the update that follows. A 'V' that fails to resynchronise shows up as an error or a lost update on the very next command. A wrong channel choice shows up on gain as soon as chan_sel changes.

// File: rtl/vol_cmd_pkg.sv
// Shared types and character codes for the volume command parser.
// Assumes 8-bit ASCII bytes.
package vol_cmd_pkg;
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_OPC,
        PS_LDIG,
        PS_RMARK,
        PS_RDIG,
        PS_TERM
    } parse_state_t;

    localparam logic [7:0] CH_V  = 8'h56;
    localparam logic [7:0] CH_L  = 8'h4C;
    localparam logic [7:0] CH_R  = 8'h52;
    localparam logic [7:0] CH_CR = 8'h0D;
endpackage

// File: rtl/vol_hex_decode.sv
// Combinational hex-character decoder.
// Converts an ASCII byte into a 4-bit nibble and flags whether the byte is a
// hex digit. When LOWER_OK is 1, the lowercase letters a-f are accepted too.
module vol_hex_decode #(
    parameter bit LOWER_OK = 1'b1
) (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib
);
    logic       dig_hit;
    logic       up_hit;
    logic       lo_hit;
    logic [7:0] dig_off;
    logic [7:0] up_off;
    logic [7:0] lo_off;

    // Digit and uppercase letter ranges.
    always_comb begin
        dig_hit = (ch >= 8'h30) && (ch <= 8'h39);
        up_hit  = (ch >= 8'h41) && (ch <= 8'h46);
        dig_off = ch - 8'h30;
        up_off  = ch - 8'h37;
        lo_off  = ch - 8'h57;
    end

    // Lowercase letters, present only when enabled.
    generate
        if (LOWER_OK) begin : g_lower
            assign lo_hit = (ch >= 8'h61) && (ch <= 8'h66);
        end else begin : g_no_lower
            assign lo_hit = 1'b0;
        end
    endgenerate

    // Select the nibble value of the range that matched.
    always_comb begin
        is_hex = dig_hit || up_hit || lo_hit;
        if (dig_hit)     nib = dig_off[3:0];
        else if (up_hit) nib = up_off[3:0];
        else if (lo_hit) nib = lo_off[3:0];
        else             nib = 4'h0;
    end
endmodule

// File: rtl/vol_cmd_fsm.sv
// Command parsing state machine with shadow and committed volume registers.
// Assumes VOL_W is a multiple of 4. Each field is VOL_W/4 hex digits, with
// the most significant digit first. The volumes are written only on a CR in
// the terminator position. A 'V' always restarts parsing.
module vol_cmd_fsm
    import vol_cmd_pkg::*;
#(
    parameter int VOL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             is_hex,
    input  logic [3:0]       nib,
    output logic [VOL_W-1:0] left_vol,
    output logic [VOL_W-1:0] right_vol,
    output logic             update,
    output logic             error
);
    localparam int DIGITS = VOL_W / 4;
    localparam int CNT_W  = $clog2(DIGITS + 1);
    localparam logic [CNT_W-1:0] LAST_DIG = CNT_W'(DIGITS - 1);

    parse_state_t     state;
    logic             full_form;
    logic [CNT_W-1:0] dig_cnt;
    logic [VOL_W-1:0] sh_left;
    logic [VOL_W-1:0] sh_right;
    logic [VOL_W-1:0] nib_ext;

    // Zero-extend the decoded nibble to the volume width.
    assign nib_ext = VOL_W'(nib);

    // Advance the parser on each valid byte and write the volumes on a good CR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PS_IDLE;
            full_form <= 1'b0;
            dig_cnt   <= '0;
            sh_left   <= '0;
            sh_right  <= '0;
            left_vol  <= '0;
            right_vol <= '0;
            update    <= 1'b0;
            error     <= 1'b0;
        end else begin
            update <= 1'b0;
            error  <= 1'b0;
            if (byte_valid) begin
                if (byte_data == CH_V) begin
                    state   <= PS_OPC;
                    dig_cnt <= '0;
                end else begin
                    case (state)
                        PS_IDLE: begin
                        end
                        PS_OPC: begin
                            if (byte_data == CH_L) begin
                                full_form <= 1'b1;
                                dig_cnt   <= '0;
                                state     <= PS_LDIG;
                            end else if (is_hex) begin
                                full_form <= 1'b0;
                                sh_left   <= (sh_left << 4) | nib_ext;
                                if (DIGITS == 1) begin
                                    dig_cnt <= '0;
                                    state   <= PS_RDIG;
                                end else begin
                                    dig_cnt <= CNT_W'(1);
                                    state   <= PS_LDIG;
                                end
                            end else begin
                                error <= 1'b1;
                                state <= PS_IDLE;
                            end
                        end
                        PS_LDIG: begin
                            if (is_hex) begin
                                sh_left <= (sh_left << 4) | nib_ext;
                                if (dig_cnt == LAST_DIG) begin
                                    dig_cnt <= '0;
                                    state   <= full_form ? PS_RMARK : PS_RDIG;
                                end else begin
                                    dig_cnt <= dig_cnt + 1'b1;
                                end
                            end else begin
                                error <= 1'b1;
                                state <= PS_IDLE;
                            end
                        end
                        PS_RMARK: begin
                            if (byte_data == CH_R) begin
                                dig_cnt <= '0;
                                state   <= PS_RDIG;
                            end else begin
                                error <= 1'b1;
                                state <= PS_IDLE;
                            end
                        end
                        PS_RDIG: begin
                            if (is_hex) begin
                                sh_right <= (sh_right << 4) | nib_ext;
                                if (dig_cnt == LAST_DIG) begin
                                    dig_cnt <= '0;
                                    state   <= PS_TERM;
                                end else begin
                                    dig_cnt <= dig_cnt + 1'b1;
                                end
                            end else begin
                                error <= 1'b1;
                                state <= PS_IDLE;
                            end
                        end
                        PS_TERM: begin
                            if (byte_data == CH_CR) begin
                                left_vol  <= sh_left;
                                right_vol <= sh_right;
                                update    <= 1'b1;
                            end else begin
                                error <= 1'b1;
                            end
                            state <= PS_IDLE;
                        end
                        default: state <= PS_IDLE;
                    endcase
                end
            end
        end
    end

    AST_UPDATE_NEEDS_CR: assert property (@(posedge clk) disable iff (!rst_n)
        update |-> $past(byte_valid && (byte_data == CH_CR))); // R2
    AST_NO_UPD_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(update && error)); // R5
    AST_ERR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(byte_valid)); // R6
    AST_VOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !update |-> ($stable(left_vol) && $stable(right_vol))); // R9
    AST_RESTART_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(byte_valid && (byte_data == CH_V)) |-> !error); // R7
endmodule

// File: rtl/vol_channel_pick.sv
// Selects the volume this speaker applies, from the static channel-select pin.
// Assumes chan_sel is tied off or changes only rarely. The path is combinational.
module vol_channel_pick #(
    parameter int VOL_W = 8
) (
    input  logic             chan_sel,
    input  logic [VOL_W-1:0] left_vol,
    input  logic [VOL_W-1:0] right_vol,
    output logic [VOL_W-1:0] gain
);
    // Route the selected channel's volume to the gain output.
    always_comb begin
        gain = chan_sel ? right_vol : left_vol;
    end
endmodule

// File: rtl/vol_cmd_parser.sv
// Top level of the ASCII volume command parser.
// Decodes hex characters, parses long-form and short-form commands, and picks
// the volume for this speaker's channel. Assumes one byte per cycle at most.
module vol_cmd_parser #(
    parameter int VOL_W    = 8,
    parameter bit LOWER_OK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             chan_sel,
    output logic [VOL_W-1:0] left_vol,
    output logic [VOL_W-1:0] right_vol,
    output logic [VOL_W-1:0] gain,
    output logic             update,
    output logic             error
);
    logic       is_hex;
    logic [3:0] nib;

    vol_hex_decode #(.LOWER_OK(LOWER_OK)) u_hex (
        .ch     (byte_data),
        .is_hex (is_hex),
        .nib    (nib)
    );

    vol_cmd_fsm #(.VOL_W(VOL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .is_hex     (is_hex),
        .nib        (nib),
        .left_vol   (left_vol),
        .right_vol  (right_vol),
        .update     (update),
        .error      (error)
    );

    vol_channel_pick #(.VOL_W(VOL_W)) u_pick (
        .chan_sel  (chan_sel),
        .left_vol  (left_vol),
        .right_vol (right_vol),
        .gain      (gain)
    );
endmodule

// File: tb/test_vol_cmd_parser.sv
`timescale 1ns/1ps
module test_vol_cmd_parser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       chan_sel = 1'b0;
    logic [7:0] left_vol, right_vol, gain;
    logic       update, error;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] exp_l = 8'h00;
    logic [7:0] exp_r = 8'h00;

    vol_cmd_parser i_vol_cmd_parser (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .chan_sel(chan_sel), .left_vol(left_vol), .right_vol(right_vol),
        .gain(gain), .update(update), .error(error)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return (lower ? 8'h57 : 8'h37) + {4'h0, n};
    endfunction

    function automatic logic [7:0] exp_gain(input logic sel);
        return sel ? exp_r : exp_l;
    endfunction

    // Offer one byte, then sample the pulses in the following cycle.
    task automatic send_byte(input logic [7:0] b, output bit u, output bit e);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        u = update;
        e = error;
    endtask

    task automatic check_vols(input string req);
        chk({req, " left"}, left_vol, exp_l);
        chk({req, " right"}, right_vol, exp_r);
        chk({req, " gain"}, gain, exp_gain(chan_sel));
    endtask

    // Send a command. bad_pos >= 0 replaces that digit position with bad_ch.
    task automatic send_cmd(input logic [7:0] l, input logic [7:0] r, input bit full,
                            input bit lower, input int bad_pos, input logic [7:0] bad_ch,
                            input string req);
        logic [7:0] q[$];
        int dpos[$];
        bit u, e, aborted;
        q.push_back(8'h56);
        if (full) q.push_back(8'h4C);
        dpos.push_back(q.size()); q.push_back(hexc(l[7:4], lower));
        dpos.push_back(q.size()); q.push_back(hexc(l[3:0], lower));
        if (full) q.push_back(8'h52);
        dpos.push_back(q.size()); q.push_back(hexc(r[7:4], lower));
        dpos.push_back(q.size()); q.push_back(hexc(r[3:0], lower));
        q.push_back(8'h0D);
        if (bad_pos >= 0) q[dpos[bad_pos]] = bad_ch;
        aborted = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            send_byte(q[i], u, e);
            if (bad_pos >= 0 && i == dpos[bad_pos]) begin
                chk({req, " R5 error on bad digit"}, e, 1'b1);
                chk({req, " R5 no update"}, u, 1'b0);
                aborted = 1'b1;
            end else if (i == q.size() - 1 && !aborted) begin
                exp_l = l;
                exp_r = r;
                chk({req, " update on CR"}, u, 1'b1);
                chk({req, " no error"}, e, 1'b0);
            end else begin
                chk({req, " R7 no pulse"}, {u, e}, 2'b00);
            end
        end
        check_vols(req);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit u, e;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset left", left_vol, 8'h00);
        chk("R1 reset right", right_vol, 8'h00);
        chk("R1 reset update", update, 1'b0);
        chk("R1 reset error", error, 1'b0);

        // R2 long form example.
        send_cmd(8'h42, 8'h9A, 1'b1, 1'b0, -1, 8'h00, "R2 full");
        // R3 short form with lowercase, R4.
        send_cmd(8'h3C, 8'hD4, 1'b0, 1'b1, -1, 8'h00, "R3 R4 compact lower");
        send_cmd(8'hFF, 8'h00, 1'b1, 1'b1, -1, 8'h00, "R4 full lower");

        // R8 channel selection.
        @(negedge clk); chan_sel = 1'b1; #1;
        chk("R8 gain right", gain, exp_r);
        @(negedge clk); chan_sel = 1'b0; #1;
        chk("R8 gain left", gain, exp_l);

        // R9 byte_valid low has no effect.
        @(negedge clk); byte_data = 8'h56;
        @(negedge clk); byte_data = 8'h0D;
        @(negedge clk);
        chk("R9 invalid cycles update", update, 1'b0);
        check_vols("R9 invalid cycles");

        // R5 bad digit and early CR.
        send_cmd(8'h11, 8'h22, 1'b1, 1'b0, 2, 8'h47, "R5 bad digit G");
        send_byte(8'h56, u, e); send_byte(8'h4C, u, e); send_byte(8'h31, u, e);
        send_byte(8'h0D, u, e);
        chk("R5 early CR error", e, 1'b1);
        check_vols("R5 early CR");

        // R6 wrong marker, terminator and opcode follower.
        send_byte(8'h56, u, e); send_byte(8'h4C, u, e); send_byte(8'h31, u, e);
        send_byte(8'h32, u, e); send_byte(8'h58, u, e);
        chk("R6 bad marker error", e, 1'b1);
        send_byte(8'h56, u, e); send_byte(8'h31, u, e); send_byte(8'h32, u, e);
        send_byte(8'h33, u, e); send_byte(8'h34, u, e); send_byte(8'h35, u, e);
        chk("R6 bad terminator error", e, 1'b1);
        chk("R6 bad terminator no update", u, 1'b0);
        send_byte(8'h56, u, e); send_byte(8'h5A, u, e);
        chk("R6 bad opcode follower error", e, 1'b1);
        check_vols("R6 after aborts");

        // R7 restart mid-command, then idle garbage.
        send_byte(8'h56, u, e); send_byte(8'h4C, u, e); send_byte(8'h37, u, e);
        send_cmd(8'h11, 8'h22, 1'b0, 1'b0, -1, 8'h00, "R7 restart");
        send_byte(8'h41, u, e);
        chk("R7 idle garbage", {u, e}, 2'b00);
        send_byte(8'h0D, u, e);
        chk("R7 idle CR", {u, e}, 2'b00);
        check_vols("R7 idle");

        // Random mix of forms, cases, channel and corruptions.
        for (int k = 0; k < 400; k++) begin
            logic [7:0] rl, rr, bc;
            int bp;
            rl = 8'($urandom);
            rr = 8'($urandom);
            bp = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3)) : -1;
            case ($urandom_range(0, 3))
                0: bc = 8'h47;
                1: bc = 8'h0D;
                2: bc = 8'h20;
                default: bc = 8'h7A;
            endcase
            @(negedge clk); chan_sel = 1'($urandom);
            send_cmd(rl, rr, 1'($urandom), 1'($urandom), bp, bc,
                     bp >= 0 ? "R5 random corrupt" : "R2 R3 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule